// File: doc/BRIEF.md
# Four-Phase Handshake Stage Controller

This block is the control half of a self-timed pipeline stage. It receives work from the stage before it through an input request/acknowledge pair and passes results to the stage after it through an output request/acknowledge pair. In between it launches the local datapath with a start level and waits for the datapath's done level. All six wires follow a return-to-zero discipline. Every wire that rose in a transfer must fall again, in the same relative order, before the next transfer can begin.

The result is bundled data. The downstream request is raised only once done is high, so the data bits may settle freely before that point. The controller is a clocked state machine. Each asynchronous input (`up_req`, `dp_done`, `dn_ack`) passes through a synchronizer of `SYNC_STAGES` flops before the machine looks at it. Any input level that the current phase does not allow sets a sticky error flag.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `dp_start`, `dn_req` and `up_ack` are all 0 and `proto_err` is 0 until an input moves.
- R2: After `up_req` rises in the idle phase, `dp_start` rises. `dp_start` stays high until `up_req` has fallen.
- R3: `dn_req` rises only after `dp_done` has been seen high. While `dp_done` stays low, `dn_req` stays low no matter how long the wait lasts.
- R4: `up_ack` rises only after `dn_ack` has been seen high, and falls only after `dn_ack` has been seen low.
- R5: In the return phase, `dp_start` falls once `up_req` is low, then `dn_req` falls once `dp_done` is low, then `up_ack` falls once `dn_ack` is low. The controller then returns to the idle phase and can take another transfer.
- R6: Each output change caused by an input change appears on the (`SYNC_STAGES`+1)-th rising clock edge after that input change, which is the third edge by default. Before that edge the output keeps its old value.
- R7: At most one of `dp_start`, `dn_req` and `up_ack` changes on any clock edge.
- R8: `dp_done` seen high while `dp_start` is low and the controller is idle sets `proto_err` with the same latency as R6. The outputs do not advance.
- R9: `dn_ack` seen high before `dn_req` has risen, or `up_req` seen low before `up_ack` has risen, sets `proto_err`.
- R10: `proto_err` stays 1 after the offending input returns to a legal level. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_req | input | 1 | Request from the upstream stage (asynchronous) |
| up_ack | output | 1 | Acknowledge to the upstream stage |
| dp_start | output | 1 | Start level to the datapath |
| dp_done | input | 1 | Completion level from the datapath (asynchronous) |
| dn_req | output | 1 | Request to the downstream stage |
| dn_ack | input | 1 | Acknowledge from the downstream stage (asynchronous) |
| proto_err | output | 1 | Sticky flag for an out-of-order input |

## Verification
Two functions can act in the same cycle. The first is phase advancement, which is driven by a legal input edge. The second is error detection, which judges every synchronized input level against the current phase. The bench makes them meet by driving illegal edges in the idle phase and in the first forward phase, which are the same cycles in which a legal edge would advance the machine. It then checks that `proto_err` rises on exactly the third edge while the outputs stay put. In the random legal cycles the bench checks that every advance leaves `proto_err` low.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_LAUNCH    = 3'd1,
    PH_OFFER     = 3'd2,
    PH_GRANT     = 3'd3,
    PH_RTZ_LNCH  = 3'd4,
    PH_RTZ_OFFER = 3'd5
  } phase_e;

  typedef struct packed {
    logic start;
    logic req;
    logic ack;
  } ctrl_out_t;

  function automatic ctrl_out_t phase_outputs(phase_e ph);
    ctrl_out_t o;
    o = '0;
    case (ph)
      PH_LAUNCH:    o = '{start: 1'b1, req: 1'b0, ack: 1'b0};
      PH_OFFER:     o = '{start: 1'b1, req: 1'b1, ack: 1'b0};
      PH_GRANT:     o = '{start: 1'b1, req: 1'b1, ack: 1'b1};
      PH_RTZ_LNCH:  o = '{start: 1'b0, req: 1'b1, ack: 1'b1};
      PH_RTZ_OFFER: o = '{start: 1'b0, req: 1'b0, ack: 1'b1};
      default:      o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hs_level_sync.sv
module hs_level_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
endmodule

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
  import hs_stage_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_s,
  input  logic      done_s,
  input  logic      ack_s,
  output phase_e    phase,
  output ctrl_out_t outs
);
  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:      if (req_s)   phase_nx = PH_LAUNCH;
      PH_LAUNCH:    if (done_s)  phase_nx = PH_OFFER;
      PH_OFFER:     if (ack_s)   phase_nx = PH_GRANT;
      PH_GRANT:     if (!req_s)  phase_nx = PH_RTZ_LNCH;
      PH_RTZ_LNCH:  if (!done_s) phase_nx = PH_RTZ_OFFER;
      PH_RTZ_OFFER: if (!ack_s)  phase_nx = PH_IDLE;
      default:                   phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  assign outs = phase_outputs(phase);
endmodule

// File: rtl/hs_order_monitor.sv
module hs_order_monitor
  import hs_stage_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   req_s,
  input  logic   done_s,
  input  logic   ack_s,
  output logic   err
);
  logic bad;
  logic err_set;

  // Each phase permits some inputs to be only at one level; moving ones are free.
  always_comb begin
    bad = 1'b0;
    case (phase)
      PH_IDLE:      bad = done_s | ack_s;
      PH_LAUNCH:    bad = !req_s | ack_s;
      PH_OFFER:     bad = !req_s | !done_s;
      PH_GRANT:     bad = !done_s | !ack_s;
      PH_RTZ_LNCH:  bad = req_s | !ack_s;
      PH_RTZ_OFFER: bad = req_s | done_s;
      default:      bad = 1'b1;
    endcase
  end

  assign err_set = bad & !err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (err_set) err <= 1'b1;
  end
endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
  import hs_stage_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  output logic up_ack,
  output logic dp_start,
  input  logic dp_done,
  output logic dn_req,
  input  logic dn_ack,
  output logic proto_err
);
  localparam int NIN = 3;

  logic [1:0]     rst_pipe;
  logic           rst_n_i;
  logic [NIN-1:0] in_sync;
  logic           req_s, done_s, ack_s;
  phase_e         phase;
  ctrl_out_t      outs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  hs_level_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .d_async ({up_req, dp_done, dn_ack}),
    .q_sync  (in_sync)
  );
  assign {req_s, done_s, ack_s} = in_sync;

  hs_phase_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .req_s  (req_s),
    .done_s (done_s),
    .ack_s  (ack_s),
    .phase  (phase),
    .outs   (outs)
  );

  hs_order_monitor u_mon (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .phase  (phase),
    .req_s  (req_s),
    .done_s (done_s),
    .ack_s  (ack_s),
    .err    (proto_err)
  );

  assign dp_start = outs.start;
  assign dn_req   = outs.req;
  assign up_ack   = outs.ack;
endmodule

// File: rtl/hs_stage_ctrl_chk.sv
module hs_stage_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_s,
  input logic done_s,
  input logic ack_s,
  input logic dp_start,
  input logic dn_req,
  input logic up_ack,
  input logic proto_err
);
  // R2
  start_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_start) |-> $past(req_s));

  // R3
  req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(done_s));

  // R4
  ack_rise_after_dnack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack) |-> $past(ack_s));

  // R4
  ack_fall_after_dnack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ack) |-> !$past(ack_s));

  // R7
  single_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dp_start, dn_req, up_ack} ^ $past({dp_start, dn_req, up_ack})) <= 1);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind hs_stage_ctrl hs_stage_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_s     (req_s),
  .done_s    (done_s),
  .ack_s     (ack_s),
  .dp_start  (dp_start),
  .dn_req    (dn_req),
  .up_ack    (up_ack),
  .proto_err (proto_err)
);

// File: tb/sim_hs_stage_ctrl.sv
`timescale 1ns/1ps
module sim_hs_stage_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic up_req, dp_done, dn_ack;
  logic up_ack, dp_start, dn_req, proto_err;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  hs_stage_ctrl #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .up_req(up_req), .up_ack(up_ack),
    .dp_start(dp_start), .dp_done(dp_done),
    .dn_req(dn_req), .dn_ack(dn_ack),
    .proto_err(proto_err)
  );

  // Expected {start, req, ack} after the k-th legal input edge of a transfer
  function automatic logic [2:0] exp_outs(int k);
    case (k)
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b111;
      4: return 3'b011;
      5: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] obs();
    return {dp_start, dn_req, up_ack};
  endfunction

  task automatic check3(string tag, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_req = 1'b0; dp_done = 1'b0; dn_ack = 1'b0;
    repeat (3) @(negedge clk);
    check3("R1 in reset", obs(), 3'b000);
    check1("R1 err in reset", proto_err, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check3("R1 after release", obs(), 3'b000);
    check1("R1 err after release", proto_err, 1'b0);
  endtask

  // Drive one input (0 up_req, 1 dp_done, 2 dn_ack) and check timing (R6).
  task automatic drive_step(int which, logic lvl, int k, int gap, string tag);
    repeat (gap) @(negedge clk);
    check3({tag, " hold before edge"}, obs(), exp_outs(k - 1));
    case (which)
      0: up_req = lvl;
      1: dp_done = lvl;
      default: dn_ack = lvl;
    endcase
    repeat (2) @(posedge clk);
    @(negedge clk);
    check3({"R6 ", tag, " not before third edge"}, obs(), exp_outs(k - 1));
    @(posedge clk);
    @(negedge clk);
    check3({"R6 ", tag, " on third edge"}, obs(), exp_outs(k));
    check1({"R10 ", tag, " no error on legal edge"}, proto_err, 1'b0);
  endtask

  task automatic full_transfer(int maxgap);
    drive_step(0, 1'b1, 1, $urandom_range(maxgap), "R2 start rise");
    drive_step(1, 1'b1, 2, $urandom_range(maxgap), "R3 req rise");
    drive_step(2, 1'b1, 3, $urandom_range(maxgap), "R4 ack rise");
    drive_step(0, 1'b0, 4, $urandom_range(maxgap), "R5 start fall");
    drive_step(1, 1'b0, 5, $urandom_range(maxgap), "R5 req fall");
    drive_step(2, 1'b0, 6, $urandom_range(maxgap), "R5 ack fall");
  endtask

  task automatic expect_err(string tag, logic [2:0] hold);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check1({tag, " flag not before third edge"}, proto_err, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check1({tag, " flag on third edge"}, proto_err, 1'b1);
    check3({tag, " outputs unchanged"}, obs(), hold);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; up_req = 1'b0; dp_done = 1'b0; dn_ack = 1'b0;
    do_reset();

    // Directed: back-to-back transfers with no idle gap
    full_transfer(0);
    full_transfer(0);

    // Random legal transfers with random environment delays
    for (int i = 0; i < 20; i++) full_transfer(6);

    // R3: long stall of the datapath, downstream request must stay low
    drive_step(0, 1'b1, 1, 1, "R2 start before stall");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 5 == 0) check1("R3 dn_req low while done low", dn_req, 1'b0);
    end
    drive_step(1, 1'b1, 2, 0, "R3 req after stall");
    drive_step(2, 1'b1, 3, 0, "R4 ack after stall");
    drive_step(0, 1'b0, 4, 0, "R5 rtz a");
    drive_step(1, 1'b0, 5, 0, "R5 rtz b");
    drive_step(2, 1'b0, 6, 0, "R5 rtz c");

    // R8: done high while idle
    @(negedge clk);
    dp_done = 1'b1;
    expect_err("R8 done while idle", 3'b000);
    @(negedge clk);
    dp_done = 1'b0;
    repeat (6) @(negedge clk);
    check1("R10 flag stays after done drops", proto_err, 1'b1);
    check3("R8 outputs still idle", obs(), 3'b000);
    do_reset();
    check1("R10 reset clears flag", proto_err, 1'b0);

    // R9: downstream ack before downstream request
    drive_step(0, 1'b1, 1, 0, "R2 start for R9a");
    @(negedge clk);
    dn_ack = 1'b1;
    expect_err("R9 early dn_ack", 3'b100);
    do_reset();

    // R9: upstream request withdrawn before acknowledge
    drive_step(0, 1'b1, 1, 0, "R2 start for R9b");
    @(negedge clk);
    up_req = 1'b0;
    expect_err("R9 early req drop", 3'b100);
    repeat (5) @(negedge clk);
    check1("R10 flag held", proto_err, 1'b1);
    do_reset();

    // Controller still works after the error episodes
    full_transfer(3);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule